// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block is one receive channel of a 16550-class asynchronous serial port. A programmable 16-bit divisor, loaded one byte at a time, sets the rate of a sample tick that runs at sixteen times the baud rate. A receive state machine uses this tick to find the start bit and to confirm it at mid-bit. It then samples eight data bits, an optional parity bit and the stop bit in the middle of each bit.

Each finished character goes into a receive queue as an 11-bit entry: the data byte plus three error flags that belong to that byte alone. The oldest entry appears directly on the read port, so the head of the queue is the receive buffer. Software, or a bus adapter, pops entries with a one-cycle strobe and watches the empty flag, the fill count and a sticky overrun flag. The overrun flag clears when status is read.

Top module: `uart_rx_channel`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rx_empty` is 1, `rx_count` is 0 and `overrun` is 0.
- R2: The divisor is the 16-bit value {high byte, low byte}, written by `div_wr_hi`/`div_wr_lo` from `div_wdata`; its reset value is 0. One serial bit lasts 16 × divisor clock cycles. A divisor of 0 stops the sample tick, and the receiver then accepts no characters.
- R3: A low pulse on `rxd` that is high again when resampled half a bit after it was detected is dropped as a glitch and queues nothing.
- R4: Eight data bits are received least significant bit first, and the byte appears on `rd_data` once it reaches the head of the queue.
- R5: When `par_en`=1, one parity bit follows the data. With `par_odd`=0 the data and parity bits together must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `rd_err[0]`. When `par_en`=0, `rd_err[0]` is 0.
- R6: A stop bit sampled low sets the framing flag `rd_err[1]`.
- R7: The break flag `rd_err[2]` is set when the data bits, any parity bit and the stop bit were all low. A break always carries the framing flag as well.
- R8: Entries leave in arrival order. A pulse on `rd_pop` while the queue is not empty removes the head, and `rx_count` reports the number of entries, which never exceeds FIFO_DEPTH.
- R9: A character that completes while the queue holds FIFO_DEPTH entries is discarded, the queue is left unchanged and `overrun` becomes 1. `overrun` stays 1 until a `stat_rd` pulse clears it.
- R10: A pulse on `rd_pop` while the queue is empty has no effect.
- R11: A start bit that follows a stop bit with no idle time between them is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wdata | input | 8 | Byte written to the divisor |
| div_wr_lo | input | 1 | Write strobe for the low divisor byte |
| div_wr_hi | input | 1 | Write strobe for the high divisor byte |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| rxd | input | 1 | Serial input, idles high |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Data byte of the head entry |
| rd_err | output | 3 | Head entry flags: [0] parity, [1] framing, [2] break |
| rx_empty | output | 1 | Queue is empty |
| rx_count | output | $clog2(FIFO_DEPTH+1) | Number of queued entries |
| overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
The bench builds the block with the default depth of 16 entries. With this depth the queue can be filled, and made to overrun, with seventeen characters in a short run. The divisor is set from the bench at run time. A divisor of 4 gives 64-clock bits, which keeps the pattern table fast. A divisor of 0x0100 exercises the high divisor byte, and a divisor of 0 shows that the receiver stops. The short bit time also lets the bench place a glitch shorter than half a bit with precision.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // Parity bit a sender would append to make the total count match the mode.
  function automatic logic par_bit_for(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // A break holds the line low for the whole character.
  function automatic logic is_break(input logic [7:0] d, input logic pen,
                                    input logic pbit, input logic stop);
    return (d == 8'h00) && !stop && (!pen || !pbit);
  endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  wdata,
  input  logic        wr_lo,
  input  logic        wr_hi,
  output logic [15:0] divisor,
  output logic        tick
);
  logic [15:0] cnt;
  logic        wrap;

  assign wrap = (divisor != 16'd0) && (cnt >= divisor - 16'd1);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= 16'd0;
    end else begin
      if (wr_lo) divisor[7:0]  <= wdata;
      if (wr_hi) divisor[15:8] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= 16'd0;
    else if (divisor == 16'd0)   cnt <= 16'd0;
    else if (wrap)               cnt <= 16'd0;
    else                         cnt <= cnt + 16'd1;
  end
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      done,
  output rx_entry_t entry,
  output logic      glitch
);
  logic [1:0] sync;
  logic       rx_s;
  logic       line_prev;
  rx_state_t  state;
  logic [3:0] tcnt;
  logic [2:0] bitn;
  logic [7:0] shreg;
  logic       pbit;
  logic       mid;

  assign rx_s   = sync[1];
  assign mid    = tick && (tcnt == 4'd15);
  assign glitch = tick && (state == RX_START) && (tcnt == 4'd7) && rx_s;
  assign done   = mid && (state == RX_STOP);

  always_comb begin
    entry.data = shreg;
    entry.pe   = par_en && (pbit != par_bit_for(shreg, par_odd));
    entry.fe   = !rx_s;
    entry.brk  = is_break(shreg, par_en, pbit, rx_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      line_prev <= 1'b1;
      tcnt      <= 4'd0;
      bitn      <= 3'd0;
      shreg     <= 8'd0;
      pbit      <= 1'b0;
    end else if (tick) begin
      case (state)
        RX_IDLE: begin
          line_prev <= rx_s;
          if (line_prev && !rx_s) begin
            state <= RX_START;
            tcnt  <= 4'd0;
          end
        end
        RX_START: begin
          if (tcnt == 4'd7) begin
            tcnt <= 4'd0;
            bitn <= 3'd0;
            if (rx_s) begin
              state     <= RX_IDLE;
              line_prev <= 1'b1;
            end else begin
              state <= RX_DATA;
            end
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        RX_DATA: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            shreg <= {rx_s, shreg[7:1]};
            bitn  <= bitn + 3'd1;
            if (bitn == 3'd7) state <= par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            pbit  <= rx_s;
            state <= RX_STOP;
          end
        end
        RX_STOP: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            state     <= RX_IDLE;
            line_prev <= rx_s;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  input  logic          stat_rd,
  output rx_entry_t     head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop,
  output logic          overrun
);
  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign drop    = push && full;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (drop)         overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_channel.sv
module uart_rx_channel
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [7:0]                         div_wdata,
  input  logic                               div_wr_lo,
  input  logic                               div_wr_hi,
  input  logic                               par_en,
  input  logic                               par_odd,
  input  logic                               rxd,
  input  logic                               rd_pop,
  input  logic                               stat_rd,
  output logic [7:0]                         rd_data,
  output logic [2:0]                         rd_err,
  output logic                               rx_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    rx_count,
  output logic                               overrun
);
  logic [15:0] divisor;
  logic        tick;
  logic        char_done;
  logic        char_drop;
  logic        start_glitch;
  rx_entry_t   done_entry;
  rx_entry_t   head;
  logic [2:0]  done_err;

  assign done_err = {done_entry.brk, done_entry.fe, done_entry.pe};
  assign rd_data  = head.data;
  assign rd_err   = {head.brk, head.fe, head.pe};

  uart_rx_baud u_baud (
    .clk(clk), .rst_n(rst_n), .wdata(div_wdata), .wr_lo(div_wr_lo),
    .wr_hi(div_wr_hi), .divisor(divisor), .tick(tick)
  );

  uart_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .done(char_done), .entry(done_entry),
    .glitch(start_glitch)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(char_done), .push_entry(done_entry),
    .pop(rd_pop), .stat_rd(stat_rd), .head(head), .count(rx_count),
    .empty(rx_empty), .drop(char_drop), .overrun(overrun)
  );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   divisor,
  input logic          tick,
  input logic          char_done,
  input logic          char_drop,
  input logic          start_glitch,
  input logic [2:0]    done_err,
  input logic          rd_pop,
  input logic          rx_empty,
  input logic [CW-1:0] rx_count,
  input logic          overrun
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (rx_empty && !overrun)); // R1
  AST_ZERO_DIV_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == 16'd0) |-> !tick); // R2
  AST_GLITCH_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_glitch && !rd_pop) |=> $stable(rx_count)); // R3
  AST_BREAK_HAS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && done_err[2]) |-> done_err[1]); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R8
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    char_drop |-> (rx_count == CW'(DEPTH))); // R9
  AST_DROP_SETS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    char_drop |=> overrun); // R9
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !char_done) |=> rx_empty); // R10
endmodule

bind uart_rx_channel uart_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick),
  .char_done(char_done), .char_drop(char_drop), .start_glitch(start_glitch),
  .done_err(done_err), .rd_pop(rd_pop), .rx_empty(rx_empty),
  .rx_count(rx_count), .overrun(overrun)
);

// File: tb/tb_uart_rx_channel.sv
module tb_uart_rx_channel;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NVEC  = 10;
  // Each entry: {data[7:0], par_en, par_odd, flip_parity, stop_level}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'hA5, 4'b0001}, {8'h3C, 4'b1001}, {8'h81, 4'b1101},
    {8'h5A, 4'b1011}, {8'hF0, 4'b1111}, {8'h77, 4'b0000},
    {8'h00, 4'b0000}, {8'h00, 4'b0001}, {8'hFF, 4'b1001},
    {8'h00, 4'b1000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div_wdata = 8'd0;
  logic div_wr_lo = 1'b0, div_wr_hi = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic rxd = 1'b1, rd_pop = 1'b0, stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic rx_empty, overrun;
  logic [CW-1:0] rx_count;
  int n_chk = 0, n_bad = 0, bit_clks = 64;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_rx_channel #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .div_wdata(div_wdata), .div_wr_lo(div_wr_lo),
    .div_wr_hi(div_wr_hi), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
    .rd_pop(rd_pop), .stat_rd(stat_rd), .rd_data(rd_data), .rd_err(rd_err),
    .rx_empty(rx_empty), .rx_count(rx_count), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_div(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); div_wdata = hi; div_wr_hi = 1'b1;
    @(negedge clk); div_wr_hi = 1'b0; div_wdata = lo; div_wr_lo = 1'b1;
    @(negedge clk); div_wr_lo = 1'b0;
    bit_clks = 16 * {hi, lo};
  endtask

  task automatic hold(input logic v);
    rxd = v;
    repeat (bit_clks) @(negedge clk);
  endtask

  // Sends start, data LSB first, optional parity, stop; then `gap` idle bits.
  task automatic send(input logic [7:0] d, input logic pen, input logic odd,
                      input logic flip, input logic stop, input int gap);
    hold(1'b0);
    for (int i = 0; i < 8; i++) hold(d[i]);
    if (pen) hold((^d) ^ odd ^ flip);
    hold(stop);
    for (int i = 0; i < gap; i++) hold(1'b1);
    rxd = 1'b1;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held and just after release
    check("R1 empty", rx_empty, 1);
    check("R1 count", rx_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 overrun", overrun, 0);
    check("R1 count after release", rx_count, 0);

    // R2: divisor 0 (reset value) -> nothing is received
    send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    repeat (200) @(negedge clk);
    check("R2 zero divisor count", rx_count, 0);

    set_div(8'h00, 8'h04);
    repeat (bit_clks) @(negedge clk);

    // R4 R5 R6 R7: table of patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] d; logic pen, odd, flip, stop, pb;
      logic [2:0] exp_err;
      {d, pen, odd, flip, stop} = VEC[v];
      par_en = pen; par_odd = odd;
      pb = (^d) ^ odd ^ flip;
      exp_err = {(d == 8'h00) && !stop && (!pen || !pb), !stop, pen & flip};
      send(d, pen, odd, flip, stop, 1);
      check("R4 data", rd_data, d);
      check("R5 R6 R7 flags", rd_err, exp_err);
      check("R4 count", rx_count, 1);
      pop();
      check("R8 empty after pop", rx_empty, 1);
    end
    par_en = 1'b0; par_odd = 1'b0;

    // R3: low pulse of a quarter bit is dropped
    rxd = 1'b0;
    repeat (bit_clks / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bit_clks) @(negedge clk);
    check("R3 glitch count", rx_count, 0);

    // R10: pop while empty
    pop();
    check("R10 count", rx_count, 0);
    check("R10 empty", rx_empty, 1);

    // R11 R8 R9: back-to-back fill, then one more
    for (int k = 0; k < DEPTH + 1; k++) send(8'h10 + 8'(k), 1'b0, 1'b0, 1'b0, 1'b1, 0);
    hold(1'b1);
    check("R9 count full", rx_count, DEPTH);
    check("R9 overrun set", overrun, 1);
    check("R11 head first", rd_data, 8'h10);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check("R9 overrun cleared", overrun, 0);
    for (int k = 0; k < DEPTH; k++) begin
      check("R8 order", rd_data, 8'h10 + k);
      check("R11 clean flags", rd_err, 0);
      pop();
    end
    check("R8 drained", rx_empty, 1);

    // R2: high divisor byte (divisor 0x0100)
    set_div(8'h01, 8'h00);
    repeat (bit_clks) @(negedge clk);
    send(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    check("R2 high byte data", rd_data, 8'hC3);
    check("R2 high byte count", rx_count, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule